// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block sits on the host side of a parallel NOR flash. It decides when an embedded program or erase operation inside the flash has ended. After the host has issued the command sequence, it pulses `start_i`. The block then reads the status byte of the target location through a simple read port, one read at a time, and applies one of two rules.

The first rule compares the polling bit against the written data. The second rule looks for a toggling bit across consecutive reads. Each poll ends in exactly one of three outcomes: completion, failure, or an indication that the location belongs to an erase-suspended sector.

When the flash reports that its internal time limit was exceeded, the block makes one more read before it declares a failure. The polling and toggle bits can change in the same read as the time-limit bit, so that last read decides the result. A failure confirmed this way also raises a request for the host to write the reset command. A parameter caps the number of reads in a poll. A separate single-read check reports whether the window for appending further sectors to a multi-sector erase has closed. It also flags when a sector command the host appended was probably not accepted.

Top module: `flash_status_poller`

## Requirements
- R1: After reset, `rd_req_o`, `busy_o`, `done_o`, `fail_o`, `susp_o`, `rst_cmd_o`, `win_vld_o`, `win_closed_o` and `win_rej_o` are all low.
- R2: Polling-bit mode (`tog_mode_i`=0): a read whose bit 7 equals bit 7 of `exp_data_i` ends the poll with `done_o`. A read whose bit 7 differs and whose bit 5 is low leads to another read.
- R3: When `erase_i` is high at start, the expected polling bit is forced to 1 (erased data reads FFh), whatever `exp_data_i` holds.
- R4: Toggle mode (`tog_mode_i`=1): the first read is only stored. A later read whose bit 6 and bit 2 both equal those of the read before it ends the poll with `done_o`.
- R5: A read with bit 5 high that does not decide the poll causes exactly one recheck read. If the recheck meets the completion rule, the poll ends with `done_o` and no failure. A read that meets the completion rule while bit 5 is high also counts as done.
- R6: If the recheck read still shows the operation busy, `fail_o` and `rst_cmd_o` pulse together for one cycle.
- R7: Toggle mode: a read whose bit 6 equals the previous read but whose bit 2 differs ends the poll with `susp_o` and not `done_o`.
- R8: After `MAX_POLLS` reads that are busy with bit 5 low, the poll ends with `fail_o` and without `rst_cmd_o`, and no further read is requested.
- R9: `win_chk_i` while idle makes one read. One cycle after that read, `win_vld_o` pulses, and `win_closed_o` takes bit 3 of the data and holds it.
- R10: `win_rej_o` is set by a window check whose data has bit 3 high, when an earlier window check was made since the last reset or accepted `start_i`. It is cleared by any other window check.
- R11: Every poll ends with exactly one of `done_o`, `fail_o`, `susp_o`, for one cycle, in the cycle after the deciding read. `busy_o` is high from the cycle after the start until that same cycle.
- R12: While busy, `start_i`, `win_chk_i` and changes of `tog_mode_i`, `erase_i` and `exp_data_i` have no effect on the poll in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a completion poll (taken only when idle) |
| tog_mode_i | input | 1 | 0: polling-bit rule, 1: toggle rule |
| erase_i | input | 1 | Operation is an erase; expect erased data |
| exp_data_i | input | DW | Data that was programmed |
| win_chk_i | input | 1 | Make one erase-window check read (idle only) |
| rd_req_o | output | 1 | Read request, held until `rd_valid_i` |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | DW | Status byte read from the target address |
| busy_o | output | 1 | A poll or window check is in progress |
| done_o | output | 1 | Operation completed (pulse) |
| fail_o | output | 1 | Operation failed or read cap reached (pulse) |
| susp_o | output | 1 | Location is in an erase-suspended sector (pulse) |
| rst_cmd_o | output | 1 | Request to write the reset command (pulse) |
| win_vld_o | output | 1 | Window check result valid (pulse) |
| win_closed_o | output | 1 | Erase window has closed (bit 3 of last check) |
| win_rej_o | output | 1 | Appended erase command likely not accepted |

## Verification
The time-limit flag and the completion condition can land in the same read. Either the polling bit already matches, or the toggle bit stops, while bit 5 is high. The bench provokes this in both modes by placing that byte at every position from the first read up to the read cap, and expects `done_o` with no recheck and no failure. It also feeds the flag first and the decision on the recheck read, including the suspend pattern on the recheck. The outcome and the exact number of reads consumed are compared against a model computed in the bench.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int BIT_POLL = 7;  // complement of written data while busy
  localparam int BIT_TOG  = 6;  // toggles each read while busy
  localparam int BIT_TMO  = 5;  // internal time limit exceeded
  localparam int BIT_WIN  = 3;  // sector-erase window closed
  localparam int BIT_ALT  = 2;  // toggles only in erasing/suspended sectors

  typedef enum logic [2:0] {
    VD_BUSY,
    VD_DONE,
    VD_SUSP,
    VD_TMO,
    VD_FAIL
  } verdict_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_POLL,
    ST_WIN
  } state_e;
endpackage

// File: rtl/fsp_judge.sv
module fsp_judge
  import fsp_pkg::*;
(
  input  logic     tog_mode_i,
  input  logic     exp_poll_i,
  input  logic     have_prev_i,
  input  logic     rechk_i,
  input  logic     cur_poll_i,
  input  logic     cur_tmo_i,
  input  logic     cur_tog_i,
  input  logic     prev_tog_i,
  input  logic     cur_alt_i,
  input  logic     prev_alt_i,
  output verdict_e verdict_o
);
  logic toggling, alt_moving;

  assign toggling   = cur_tog_i ^ prev_tog_i;
  assign alt_moving = cur_alt_i ^ prev_alt_i;

  always_comb begin
    verdict_o = VD_BUSY;
    if (!tog_mode_i) begin
      if (cur_poll_i == exp_poll_i) verdict_o = VD_DONE;
      else if (rechk_i)             verdict_o = VD_FAIL;
      else if (cur_tmo_i)           verdict_o = VD_TMO;
    end else if (have_prev_i) begin
      if (!toggling)                verdict_o = alt_moving ? VD_SUSP : VD_DONE;
      else if (rechk_i)             verdict_o = VD_FAIL;
      else if (cur_tmo_i)           verdict_o = VD_TMO;
    end
  end
endmodule

// File: rtl/fsp_poll_cnt.sv
module fsp_poll_cnt #(
  parameter int MAX_POLLS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(MAX_POLLS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(MAX_POLLS - 1));

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(MAX_POLLS));
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
  import fsp_pkg::*;
#(
  parameter int DW        = 8,
  parameter int MAX_POLLS = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          tog_mode_i,
  input  logic          erase_i,
  input  logic [DW-1:0] exp_data_i,
  input  logic          win_chk_i,
  output logic          rd_req_o,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic          susp_o,
  output logic          rst_cmd_o,
  output logic          win_vld_o,
  output logic          win_closed_o,
  output logic          win_rej_o
);
  localparam logic [DW-1:0] RD_USED  = DW'(8'hEC);
  localparam logic [DW-1:0] EXP_USED = DW'(8'h80);

  state_e   state_q;
  verdict_e verdict;
  logic tog_q, exp_q, have_prev_q, rechk_q, prev_tog_q, prev_alt_q, seen_chk_q;
  logic done_q, fail_q, susp_q, rstc_q, win_vld_q, win_closed_q, win_rej_q;
  logic cnt_clr, cnt_inc, cnt_last, rd_take;
  logic unused_bits;

  assign unused_bits = ^{rd_data_i & ~RD_USED, exp_data_i & ~EXP_USED};

  fsp_judge u_judge (
    .tog_mode_i (tog_q),
    .exp_poll_i (exp_q),
    .have_prev_i(have_prev_q),
    .rechk_i    (rechk_q),
    .cur_poll_i (rd_data_i[BIT_POLL]),
    .cur_tmo_i  (rd_data_i[BIT_TMO]),
    .cur_tog_i  (rd_data_i[BIT_TOG]),
    .prev_tog_i (prev_tog_q),
    .cur_alt_i  (rd_data_i[BIT_ALT]),
    .prev_alt_i (prev_alt_q),
    .verdict_o  (verdict)
  );

  assign rd_take = (state_q == ST_POLL) && rd_valid_i;
  assign cnt_clr = (state_q == ST_IDLE) && start_i;
  assign cnt_inc = rd_take && (verdict == VD_BUSY) && !cnt_last;

  fsp_poll_cnt #(.MAX_POLLS(MAX_POLLS)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .last_o(cnt_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      tog_q        <= 1'b0;
      exp_q        <= 1'b0;
      have_prev_q  <= 1'b0;
      rechk_q      <= 1'b0;
      prev_tog_q   <= 1'b0;
      prev_alt_q   <= 1'b0;
      seen_chk_q   <= 1'b0;
      done_q       <= 1'b0;
      fail_q       <= 1'b0;
      susp_q       <= 1'b0;
      rstc_q       <= 1'b0;
      win_vld_q    <= 1'b0;
      win_closed_q <= 1'b0;
      win_rej_q    <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      fail_q    <= 1'b0;
      susp_q    <= 1'b0;
      rstc_q    <= 1'b0;
      win_vld_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q     <= ST_POLL;
            tog_q       <= tog_mode_i;
            exp_q       <= erase_i | exp_data_i[BIT_POLL];
            have_prev_q <= 1'b0;
            rechk_q     <= 1'b0;
            seen_chk_q  <= 1'b0;
          end else if (win_chk_i) begin
            state_q <= ST_WIN;
          end
        end
        ST_POLL: begin
          if (rd_valid_i) begin
            have_prev_q <= 1'b1;
            prev_tog_q  <= rd_data_i[BIT_TOG];
            prev_alt_q  <= rd_data_i[BIT_ALT];
            unique case (verdict)
              VD_DONE: begin done_q <= 1'b1; state_q <= ST_IDLE; end
              VD_SUSP: begin susp_q <= 1'b1; state_q <= ST_IDLE; end
              VD_TMO:  rechk_q <= 1'b1;
              VD_FAIL: begin
                fail_q  <= 1'b1;
                rstc_q  <= 1'b1;
                state_q <= ST_IDLE;
              end
              default: if (cnt_last) begin
                fail_q  <= 1'b1;
                state_q <= ST_IDLE;
              end
            endcase
          end
        end
        ST_WIN: begin
          if (rd_valid_i) begin
            win_vld_q    <= 1'b1;
            win_closed_q <= rd_data_i[BIT_WIN];
            win_rej_q    <= rd_data_i[BIT_WIN] & seen_chk_q;
            seen_chk_q   <= 1'b1;
            state_q      <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_o     = (state_q == ST_POLL) || (state_q == ST_WIN);
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign fail_o       = fail_q;
  assign susp_o       = susp_q;
  assign rst_cmd_o    = rstc_q;
  assign win_vld_o    = win_vld_q;
  assign win_closed_o = win_closed_q;
  assign win_rej_o    = win_rej_q;

  assert_one_outcome_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, fail_o, susp_o, win_vld_o}));
  assert_outcome_after_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fail_o || susp_o) |-> $past(rd_take));
  assert_busy_ends_with_outcome_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o || fail_o || susp_o || win_vld_o));
  assert_reset_req_with_fail_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_cmd_o |-> fail_o);
  assert_recheck_is_final_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_take && rechk_q) |=> !busy_o);
  assert_reject_needs_closed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_rej_o |-> win_closed_o);
endmodule

// File: tb/tb_flash_status_poller.sv
`timescale 1ns/1ps
module tb_flash_status_poller;
  localparam int MAXP = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, tog_mode_i = 1'b0, erase_i = 1'b0, win_chk_i = 1'b0;
  logic [7:0] exp_data_i = 8'h00;
  logic rd_req_o, rd_valid_i, busy_o, done_o, fail_o, susp_o, rst_cmd_o;
  logic win_vld_o, win_closed_o, win_rej_o;
  logic [7:0] rd_data_i;

  always #2.5 clk = ~clk;

  flash_status_poller #(.DW(8), .MAX_POLLS(MAXP)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .tog_mode_i(tog_mode_i),
    .erase_i(erase_i), .exp_data_i(exp_data_i), .win_chk_i(win_chk_i),
    .rd_req_o(rd_req_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o), .susp_o(susp_o),
    .rst_cmd_o(rst_cmd_o), .win_vld_o(win_vld_o), .win_closed_o(win_closed_o),
    .win_rej_o(win_rej_o)
  );

  logic [7:0] scr [64];
  int idx = 0;
  int n_chk = 0, n_bad = 0;
  bit seen = 0, finished = 0;

  // flash model: answers each requested read from the script
  initial begin
    rd_valid_i = 1'b0;
    rd_data_i  = 8'h00;
    forever begin
      @(negedge clk);
      if (rd_req_o === 1'b1) begin
        rd_valid_i = 1'b1;
        rd_data_i  = scr[idx % 64];
        idx++;
      end else begin
        rd_valid_i = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // outcome codes: 1 done, 2 fail (cap), 3 suspended, 4 fail + reset request
  task automatic ref_eval(input bit tog, input bit ers, input logic [7:0] ex,
                          output int oc, output int nr);
    bit e7, hp, rc, t6, t2;
    logic [7:0] cur, pv;
    e7 = ers ? 1'b1 : ex[7];
    hp = 0; rc = 0; pv = 8'h00; oc = 0; nr = 0;
    for (int i = 0; i < 64; i++) begin
      cur = scr[i];
      nr  = i + 1;
      if (!tog) begin
        if (cur[7] == e7) begin oc = 1; return; end
        if (rc) begin oc = 4; return; end
        if (cur[5]) begin rc = 1; continue; end
      end else if (hp) begin
        t6 = cur[6] ^ pv[6];
        t2 = cur[2] ^ pv[2];
        if (!t6) begin oc = t2 ? 3 : 1; return; end
        if (rc) begin oc = 4; return; end
        if (cur[5]) begin rc = 1; pv = cur; continue; end
      end
      if (nr == MAXP) begin oc = 2; return; end
      hp = 1;
      pv = cur;
    end
  endtask

  task automatic run(input bit tog, input bit ers, input logic [7:0] ex,
                     input bit poke, input string tag);
    int eo, en, go, cyc;
    bit wv;
    ref_eval(tog, ers, ex, eo, en);
    idx = 0; seen = 0; wv = 0;
    @(negedge clk);
    start_i = 1; tog_mode_i = tog; erase_i = ers; exp_data_i = ex;
    @(negedge clk);
    start_i = 0; tog_mode_i = !tog; erase_i = !ers; exp_data_i = ~ex;
    cyc = 0; go = 0;
    while (go == 0 && cyc < 100) begin
      if (done_o) go = 1;
      else if (susp_o) go = 3;
      else if (fail_o) go = rst_cmd_o ? 4 : 2;
      if (win_vld_o) wv = 1;
      if (go == 0) begin
        if (poke && (cyc == 1 || cyc == 3)) begin start_i = 1; win_chk_i = 1; end
        else begin start_i = 0; win_chk_i = 0; end
        @(negedge clk);
        cyc++;
      end
    end
    start_i = 0; win_chk_i = 0;
    if (go == 0) check(0, {tag, " poll timeout"}, cyc, 100);
    check(go == eo, {tag, " outcome"}, go, eo);
    check(idx == en, {tag, " reads used"}, idx, en);
    check(busy_o == 0, {tag, " R11 busy drops with outcome"}, busy_o, 0);
    if (poke) check(wv == 0, {tag, " R12 window check ignored"}, wv, 0);
  endtask

  task automatic win(input logic [7:0] d, input string tag);
    idx = 0; scr[0] = d;
    @(negedge clk); win_chk_i = 1;
    @(negedge clk); win_chk_i = 0;
    @(negedge clk);
    check(win_vld_o == 1, {tag, " R9 valid"}, win_vld_o, 1);
    check(win_closed_o == d[3], {tag, " R9 closed"}, win_closed_o, d[3]);
    check(win_rej_o == (d[3] & seen), {tag, " R10 reject"}, win_rej_o, d[3] & seen);
    seen = 1;
  endtask

  function automatic logic [7:0] tgv(input int k);
    return (k % 2 == 1) ? 8'h55 : 8'h11;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 64; k++) scr[k] = 8'h00;
    repeat (3) @(negedge clk);
    check({rd_req_o, busy_o, done_o, fail_o, susp_o, rst_cmd_o, win_vld_o,
           win_closed_o, win_rej_o} == 9'b0, "R1 reset outputs", 1, 0);
    rst_ni = 1;
    @(negedge clk);
    check(rd_req_o == 0 && busy_o == 0, "R1 idle after reset", rd_req_o, 0);

    // R2 R5 R6 R8: polling-bit rule, busy run length swept across the cap
    for (int e = 0; e < 2; e++)
      for (int nb = 0; nb < 7; nb++)
        for (int t = 0; t < 4; t++) begin
          for (int k = 0; k < 64; k++) scr[k] = {(e == 0), 7'(k * 37) & 7'h5F};
          case (t)
            0: scr[nb] = {(e == 1), 7'h15};
            1: begin scr[nb] = {(e == 0), 7'h23}; scr[nb + 1] = {(e == 1), 7'h01}; end
            2: begin scr[nb] = {(e == 0), 7'h23}; scr[nb + 1] = {(e == 0), 7'h24}; end
            default: scr[nb] = {(e == 1), 7'h20};
          endcase
          run(0, 0, {(e == 1), 7'h2A}, 0, $sformatf("R2/R5/R6/R8 poll e=%0d nb=%0d t=%0d", e, nb, t));
        end

    // R3: erase forces expected FFh
    for (int nb = 0; nb < 4; nb++) begin
      for (int k = 0; k < 64; k++) scr[k] = {1'b0, 7'(k * 37) & 7'h5F};
      scr[nb] = 8'hFF;
      run(0, 1, 8'h00, 0, $sformatf("R3 erase nb=%0d", nb));
    end

    // R4 R5 R6 R7 R8: toggle rule
    for (int nb = 1; nb < 7; nb++)
      for (int t = 0; t < 6; t++) begin
        for (int k = 0; k < 64; k++) scr[k] = tgv(k);
        case (t)
          0: scr[nb] = scr[nb - 1];
          1: scr[nb] = scr[nb - 1] ^ 8'h04;
          2: begin scr[nb] = (scr[nb - 1] ^ 8'h40) | 8'h20; scr[nb + 1] = scr[nb]; end
          3: begin scr[nb] = (scr[nb - 1] ^ 8'h40) | 8'h20; scr[nb + 1] = scr[nb] ^ 8'h40; end
          4: begin scr[nb] = (scr[nb - 1] ^ 8'h40) | 8'h20; scr[nb + 1] = scr[nb] ^ 8'h04; end
          default: scr[nb] = scr[nb - 1] | 8'h20;
        endcase
        run(1, 0, 8'h00, 0, $sformatf("R4/R5/R6/R7/R8 toggle nb=%0d t=%0d", nb, t));
      end

    // R12: start and window check while busy, inputs changed after start
    for (int k = 0; k < 64; k++) scr[k] = tgv(k);
    scr[4] = scr[3];
    run(1, 0, 8'h80, 1, "R12 busy poke");

    // R9 R10: window checks
    win(8'h00, "R9 first open");
    win(8'h08, "R10 second closed");
    win(8'h08, "R10 third closed");
    win(8'h00, "R10 open clears");
    for (int k = 0; k < 64; k++) scr[k] = 8'h80;
    run(0, 0, 8'h80, 0, "R10 start between checks");
    win(8'h08, "R10 first after start");
    win(8'h08, "R10 second after start");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule